// File: doc/BRIEF.md
# Repeated String Operation Engine

This block runs one string operation, either once or as a repeated sequence, on behalf of an execution pipeline. The five operations are move, compare, scan, load and store. Each works on byte or word elements. A single-cycle start command supplies the operation, the element size, the repeat kind and the whole initial register context: source index, destination index, count, accumulator, zero flag, direction flag, data and extra segment values and an optional replacement segment for the source. The block then walks the elements one at a time. It issues reads and writes on a request/acknowledge memory port and keeps only one request open at a time.

Physical addresses are formed as segment times 16 plus offset, truncated to 20 bits. Reads come from the source segment at the source index, and that segment may be replaced. Reads and writes at the destination always use the extra segment at the destination index. When the run ends, the updated indices, count, accumulator and zero flag are held on the outputs, and `done` is high for one cycle. A repeat stops when the count runs out. For compare and scan it can also stop early, depending on the zero flag.

Top module: `strop_engine`

## Requirements
- R1: Source reads use address `{seg,4'h0} + si` (20 bits), where seg is `ovr_seg` when `ovr_en`=1 at start and `ds_seg` otherwise.
- R2: Destination reads and writes always use `{es_seg,4'h0} + di`. `ovr_en` never changes them.
- R3: After each element, the adjusted indices move by 1 (`word_sz`=0) or 2 (`word_sz`=1). They move up when `dir_flag`=0 and down when `dir_flag`=1, with modulo 2^16 wrap.
- R4: `op_sel` encoding is 0 move, 1 compare, 2 scan, 3 load, 4 store. Move and compare adjust both indices. Scan and store adjust only di. Load adjusts only si.
- R5: Move copies the source element to the destination. Store writes the accumulator to the destination. Load places the source element in the accumulator. A byte access uses data bits 7:0 only, and a byte load keeps accumulator bits 15:8.
- R6: Compare (source against destination) and scan (accumulator against destination) set ZF to 1 on equality of the element-sized operands and to 0 otherwise. Other operations return ZF unchanged.
- R7: Under a repeat (`rep_sel` 1 or 2), the count decrements once per element, and the run ends when the count reaches 0.
- R8: With compare or scan, `rep_sel`=1 also ends after an element that leaves ZF=0, and `rep_sel`=2 ends after one that leaves ZF=1. Move, load and store ignore ZF under either repeat value.
- R9: The indices are adjusted on the element that ends the run too, so they finish one element past it.
- R10: A repeat started with count 0, or any `op_sel` above 4, makes no memory request. `done` then rises in the cycle after the start edge, with all registers returned unchanged.
- R11: With `rep_sel` 0 or 3, exactly one element is processed and the count is returned unchanged.
- R12: At most one request is open at a time. `mem_req` and its address, write flag and data stay stable until `mem_ack`. The number of accesses equals what the operation needs (move and compare 2, others 1, per element).
- R13: `done` is a one-cycle pulse. `busy` is high from the start edge to the end of the run. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| op_sel | input | 3 | Operation code |
| rep_sel | input | 2 | 0/3 none, 1 repeat-while-equal, 2 repeat-while-not-equal |
| word_sz | input | 1 | 1 = word elements, 0 = byte |
| dir_flag | input | 1 | 1 = indices decrement |
| si_in | input | 16 | Initial source index |
| di_in | input | 16 | Initial destination index |
| cx_in | input | 16 | Initial count |
| acc_in | input | 16 | Initial accumulator |
| zf_in | input | 1 | Initial zero flag |
| ds_seg | input | 16 | Default source segment |
| es_seg | input | 16 | Destination segment |
| ovr_en | input | 1 | Replace the source segment |
| ovr_seg | input | 16 | Replacement source segment |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| si_out | output | 16 | Final source index |
| di_out | output | 16 | Final destination index |
| cx_out | output | 16 | Final count |
| acc_out | output | 16 | Final accumulator |
| zf_out | output | 1 | Final zero flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_word | output | 1 | Request is a word access |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data, byte in bits 7:0 |
| mem_ack | input | 1 | Request accepted, read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
A skipped run (count 0 under repeat, or an unknown operation) must show `done` at the first falling edge after the start edge, which is one cycle later. The bench checks that latency exactly. In every other run, `mem_req` rises the cycle after the start edge, and each access ends at the edge where `mem_ack` is sampled. Each element then spends one more cycle updating the registers, and `done` follows one cycle after the last update. The final outputs are therefore valid exactly while `done` is high, and the bench samples them at the falling edge where it first sees `done`. It never waits a fixed number of cycles, because the memory model adds a random delay of 0 to 2 cycles before each acknowledge.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned SEG_W  = 16;
  localparam int unsigned SEG_SH = 4;
  localparam int unsigned ADDR_W = SEG_W + SEG_SH;
  localparam int unsigned DAT_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_MOVE = 3'd0, OP_CMP = 3'd1, OP_SCAN = 3'd2, OP_LOAD = 3'd3, OP_STORE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0, RP_EQ = 2'd1, RP_NE = 2'd2, RP_NONE_ALT = 2'd3
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSRC, ST_RDST, ST_WDST, ST_STEP, ST_FIN
  } st_e;

  function automatic logic [OFF_W-1:0] step_delta(input logic word, input logic df);
    logic [OFF_W-1:0] mag;
    mag = word ? OFF_W'(2) : OFF_W'(1);
    return df ? (OFF_W'(0) - mag) : mag;
  endfunction

  function automatic logic [ADDR_W-1:0] seg_phys(input logic [SEG_W-1:0] seg,
                                                 input logic [OFF_W-1:0] off);
    return {seg, {SEG_SH{1'b0}}} + ADDR_W'(off);
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic op_moves_src(input op_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
  endfunction

  function automatic logic op_moves_dst(input op_e op);
    return (op != OP_LOAD);
  endfunction

  function automatic logic op_tests(input op_e op);
    return (op == OP_CMP) || (op == OP_SCAN);
  endfunction

  function automatic logic rep_active(input rep_e r);
    return (r == RP_EQ) || (r == RP_NE);
  endfunction

  function automatic logic elem_eq(input logic word, input logic [DAT_W-1:0] a,
                                   input logic [DAT_W-1:0] b);
    return word ? (a == b) : (a[BYTE_W-1:0] == b[BYTE_W-1:0]);
  endfunction

  function automatic logic [DAT_W-1:0] acc_merge(input logic word, input logic [DAT_W-1:0] old,
                                                 input logic [DAT_W-1:0] rd);
    return word ? rd : {old[DAT_W-1:BYTE_W], rd[BYTE_W-1:0]};
  endfunction

  function automatic st_e first_access(input op_e op);
    case (op)
      OP_SCAN:  return ST_RDST;
      OP_STORE: return ST_WDST;
      default:  return ST_RSRC;
    endcase
  endfunction
endpackage

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       op_in,
  input  logic [1:0]       rep_in,
  input  logic [OFF_W-1:0] cx_in,
  input  op_e              op_q,
  input  logic             cont,
  input  logic             mem_ack,
  output st_e              state,
  output logic             accept,
  output logic             skip_run,
  output logic             step_fire,
  output logic             mem_req,
  output logic             mem_we,
  output logic             busy,
  output logic             done
);
  st_e nxt;

  assign accept    = start && (state == ST_IDLE);
  assign skip_run  = accept && (!op_known(op_in) ||
                     (rep_active(rep_e'(rep_in)) && (cx_in == '0)));
  assign step_fire = (state == ST_STEP);
  assign mem_req   = (state == ST_RSRC) || (state == ST_RDST) || (state == ST_WDST);
  assign mem_we    = (state == ST_WDST);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (accept) nxt = skip_run ? ST_FIN : first_access(op_e'(op_in));
      ST_RSRC: if (mem_ack) begin
        case (op_q)
          OP_MOVE: nxt = ST_WDST;
          OP_CMP:  nxt = ST_RDST;
          default: nxt = ST_STEP;
        endcase
      end
      ST_RDST: if (mem_ack) nxt = ST_STEP;
      ST_WDST: if (mem_ack) nxt = ST_STEP;
      ST_STEP: nxt = cont ? first_access(op_q) : ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip_run |=> done && !mem_req);
  assert_busy_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/strop_dp.sv
module strop_dp
  import strop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              step_fire,
  input  st_e               state,
  input  logic              mem_ack,
  input  logic [DAT_W-1:0]  mem_rdata,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_rep,
  input  logic              cmd_word,
  input  logic              cmd_df,
  input  logic [OFF_W-1:0]  cmd_si,
  input  logic [OFF_W-1:0]  cmd_di,
  input  logic [OFF_W-1:0]  cmd_cx,
  input  logic [DAT_W-1:0]  cmd_acc,
  input  logic              cmd_zf,
  input  logic [SEG_W-1:0]  cmd_ds,
  input  logic [SEG_W-1:0]  cmd_es,
  input  logic              cmd_ovr_en,
  input  logic [SEG_W-1:0]  cmd_ovr_seg,
  output op_e               op_q,
  output logic              cont,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DAT_W-1:0]  mem_wdata,
  output logic              mem_word,
  output logic [OFF_W-1:0]  si_q,
  output logic [OFF_W-1:0]  di_q,
  output logic [OFF_W-1:0]  cx_q,
  output logic [DAT_W-1:0]  acc_q,
  output logic              zf_q
);
  rep_e             rep_q;
  logic             word_q, df_q;
  logic [SEG_W-1:0] src_seg_q, es_q;
  logic [DAT_W-1:0] src_buf, dst_buf;

  logic [OFF_W-1:0] delta;
  logic             cmp_hit, zf_after, rep_on, stop_on_flag;
  logic [OFF_W-1:0] cx_after;
  logic [DAT_W-1:0] wr_raw;

  assign delta    = step_delta(word_q, df_q);
  assign rep_on   = rep_active(rep_q);
  assign cmp_hit  = (op_q == OP_SCAN) ? elem_eq(word_q, acc_q, dst_buf)
                                      : elem_eq(word_q, src_buf, dst_buf);
  assign zf_after = op_tests(op_q) ? cmp_hit : zf_q;
  assign cx_after = rep_on ? (cx_q - OFF_W'(1)) : cx_q;
  assign stop_on_flag = op_tests(op_q) &&
                        (((rep_q == RP_EQ) && !zf_after) || ((rep_q == RP_NE) && zf_after));
  assign cont     = rep_on && (cx_after != '0) && !stop_on_flag;

  assign mem_addr  = (state == ST_RSRC) ? seg_phys(src_seg_q, si_q) : seg_phys(es_q, di_q);
  assign wr_raw    = (op_q == OP_STORE) ? acc_q : src_buf;
  assign mem_wdata = word_q ? wr_raw : {{(DAT_W-BYTE_W){1'b0}}, wr_raw[BYTE_W-1:0]};
  assign mem_word  = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_MOVE;   rep_q <= RP_NONE; word_q <= 1'b0; df_q <= 1'b0;
      src_seg_q <= '0;   es_q <= '0;
      si_q <= '0; di_q <= '0; cx_q <= '0; acc_q <= '0; zf_q <= 1'b0;
      src_buf <= '0;     dst_buf <= '0;
    end else if (accept) begin
      op_q      <= op_e'(cmd_op);
      rep_q     <= rep_e'(cmd_rep);
      word_q    <= cmd_word;
      df_q      <= cmd_df;
      src_seg_q <= cmd_ovr_en ? cmd_ovr_seg : cmd_ds;
      es_q      <= cmd_es;
      si_q      <= cmd_si;
      di_q      <= cmd_di;
      cx_q      <= cmd_cx;
      acc_q     <= cmd_acc;
      zf_q      <= cmd_zf;
    end else begin
      if (mem_ack && (state == ST_RSRC)) src_buf <= mem_rdata;
      if (mem_ack && (state == ST_RDST)) dst_buf <= mem_rdata;
      if (step_fire) begin
        if (op_moves_src(op_q)) si_q <= si_q + delta;
        if (op_moves_dst(op_q)) di_q <= di_q + delta;
        if (op_q == OP_LOAD)    acc_q <= acc_merge(word_q, acc_q, src_buf);
        cx_q <= cx_after;
        zf_q <= zf_after;
      end
    end
  end

  assert_cx_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && rep_on) |=> cx_q == $past(cx_q) - OFF_W'(1));
  assert_cx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !rep_on) |=> cx_q == $past(cx_q));
  assert_si_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && (op_q == OP_SCAN || op_q == OP_STORE)) |=> si_q == $past(si_q));
  assert_di_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && op_q == OP_LOAD) |=> di_q == $past(di_q));
  assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && op_q != OP_LOAD) |=>
      (($past(df_q) ? ($past(di_q) - di_q) : (di_q - $past(di_q))) ==
       ($past(word_q) ? OFF_W'(2) : OFF_W'(1))));
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op_sel,
  input  logic [1:0]  rep_sel,
  input  logic        word_sz,
  input  logic        dir_flag,
  input  logic [15:0] si_in,
  input  logic [15:0] di_in,
  input  logic [15:0] cx_in,
  input  logic [15:0] acc_in,
  input  logic        zf_in,
  input  logic [15:0] ds_seg,
  input  logic [15:0] es_seg,
  input  logic        ovr_en,
  input  logic [15:0] ovr_seg,
  output logic        busy,
  output logic        done,
  output logic [15:0] si_out,
  output logic [15:0] di_out,
  output logic [15:0] cx_out,
  output logic [15:0] acc_out,
  output logic        zf_out,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_word,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata
);
  st_e  state;
  op_e  op_q;
  logic accept, skip_run, step_fire, cont;

  strop_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_sel), .rep_in(rep_sel),
    .cx_in(cx_in), .op_q(op_q), .cont(cont), .mem_ack(mem_ack), .state(state),
    .accept(accept), .skip_run(skip_run), .step_fire(step_fire),
    .mem_req(mem_req), .mem_we(mem_we), .busy(busy), .done(done)
  );

  strop_dp u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .step_fire(step_fire), .state(state),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cmd_op(op_sel), .cmd_rep(rep_sel), .cmd_word(word_sz), .cmd_df(dir_flag),
    .cmd_si(si_in), .cmd_di(di_in), .cmd_cx(cx_in), .cmd_acc(acc_in), .cmd_zf(zf_in),
    .cmd_ds(ds_seg), .cmd_es(es_seg), .cmd_ovr_en(ovr_en), .cmd_ovr_seg(ovr_seg),
    .op_q(op_q), .cont(cont), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_word(mem_word), .si_q(si_out), .di_q(di_out), .cx_q(cx_out),
    .acc_q(acc_out), .zf_q(zf_out)
  );

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata) && $stable(mem_word));
  assert_regs_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_fire) |=> $stable(si_out) && $stable(di_out) && $stable(cx_out));
endmodule

// File: tb/strop_engine_test.sv
module strop_engine_test;
  localparam int MSZ = 4096;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic start = 0, word_sz = 0, dir_flag = 0, zf_in = 0, ovr_en = 0;
  logic [2:0] op_sel = 0;
  logic [1:0] rep_sel = 0;
  logic [15:0] si_in = 0, di_in = 0, cx_in = 0, acc_in = 0, ds_seg = 0, es_seg = 0, ovr_seg = 0;
  logic busy, done, zf_out, mem_req, mem_we, mem_word, mem_ack = 0;
  logic [15:0] si_out, di_out, cx_out, acc_out, mem_wdata, mem_rdata = 0;
  logic [19:0] mem_addr;

  strop_engine uut (.*);

  logic [7:0] img [MSZ];
  logic [7:0] ref_img [MSZ];
  int total = 0, bad = 0, acc_cnt = 0, wait_c = 0, cyc = 0;
  bit aborted = 0;

  // memory model: acknowledge after 0..2 idle falling edges
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (wait_c == 0) begin
        int a0, a1;
        a0 = int'(mem_addr[11:0]); a1 = (a0 + 1) % MSZ;
        if (mem_we) begin
          img[a0] = mem_wdata[7:0];
          if (mem_word) img[a1] = mem_wdata[15:8];
        end else
          mem_rdata = mem_word ? {img[a1], img[a0]} : {8'hA5, img[a0]};
        mem_ack = 1; acc_cnt++;
        wait_c = $urandom % 3;
      end else wait_c--;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired R13 act=hung exp=finished");
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // bench-side reference
  logic [15:0] e_si, e_di, e_cx, e_acc;
  logic e_zf;
  int e_acc_n;

  function automatic int loc(input logic [15:0] seg, input logic [15:0] off);
    logic [19:0] p;
    p = 20'(seg) * 20'd16 + 20'(off);
    return int'(p) % MSZ;
  endfunction

  function automatic logic [15:0] rrd(input int a, input bit w);
    return w ? {ref_img[(a+1)%MSZ], ref_img[a]} : {8'h00, ref_img[a]};
  endfunction

  task automatic rwr(input int a, input logic [15:0] v, input bit w);
    ref_img[a] = v[7:0];
    if (w) ref_img[(a+1)%MSZ] = v[15:8];
  endtask

  task automatic ref_run();
    logic [15:0] sseg, a, b, d;
    bit repeating, testing, w;
    w = word_sz;
    e_si = si_in; e_di = di_in; e_cx = cx_in; e_acc = acc_in; e_zf = zf_in; e_acc_n = 0;
    repeating = (rep_sel == 2'd1) || (rep_sel == 2'd2);
    testing = (op_sel == 3'd1) || (op_sel == 3'd2);
    sseg = ovr_en ? ovr_seg : ds_seg;
    d = w ? 16'd2 : 16'd1;
    if (dir_flag) d = -d;
    if (op_sel > 3'd4 || (repeating && cx_in == 0)) return;
    forever begin
      case (op_sel)
        3'd0: begin a = rrd(loc(sseg, e_si), w); rwr(loc(es_seg, e_di), a, w); e_acc_n += 2; end
        3'd1: begin a = rrd(loc(sseg, e_si), w); b = rrd(loc(es_seg, e_di), w);
                    e_zf = w ? (a == b) : (a[7:0] == b[7:0]); e_acc_n += 2; end
        3'd2: begin b = rrd(loc(es_seg, e_di), w);
                    e_zf = w ? (e_acc == b) : (e_acc[7:0] == b[7:0]); e_acc_n += 1; end
        3'd3: begin a = rrd(loc(sseg, e_si), w);
                    if (w) e_acc = a; else e_acc[7:0] = a[7:0]; e_acc_n += 1; end
        default: begin rwr(loc(es_seg, e_di), e_acc, w); e_acc_n += 1; end
      endcase
      if (op_sel != 3'd2 && op_sel != 3'd4) e_si = e_si + d;
      if (op_sel != 3'd3) e_di = e_di + d;
      if (!repeating) break;
      e_cx = e_cx - 1;
      if (e_cx == 0) break;
      if (testing && rep_sel == 2'd1 && !e_zf) break;
      if (testing && rep_sel == 2'd2 && e_zf) break;
    end
  endtask

  int last_cycles;

  task automatic run_cmd(input bit poke);
    int mism;
    if (aborted) return;
    for (int i = 0; i < MSZ; i++) ref_img[i] = img[i];
    ref_run();
    acc_cnt = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done) begin
      if (poke && cyc == 3 && busy) begin
        start = 1; si_in = 16'hDEAD; cx_in = 16'd1; op_sel = 3'd4;
      end else start = 0;
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin aborted = 1; break; end
    end
    start = 0;
    last_cycles = cyc;
    if (aborted) begin
      total++; bad++;
      $display("FAIL R13 done missing act=timeout exp=done");
      return;
    end
    chk("R3/R4 si_out", si_out, e_si);
    chk("R3/R4/R9 di_out", di_out, e_di);
    chk("R7/R11 cx_out", cx_out, e_cx);
    chk("R5 acc_out", acc_out, e_acc);
    chk("R6/R8 zf_out", zf_out, e_zf);
    chk("R12 access count", acc_cnt, e_acc_n);
    mism = 0;
    for (int i = 0; i < MSZ; i++) if (img[i] !== ref_img[i]) mism++;
    chk("R1/R2/R5 memory image", mism, 0);
    @(negedge clk);
    chk("R13 done single pulse", {busy, done}, 2'b00);
  endtask

  task automatic set_cmd(input logic [2:0] o, input logic [1:0] r, input bit w, input bit df,
                         input logic [15:0] si, input logic [15:0] di, input logic [15:0] cx,
                         input logic [15:0] acc);
    op_sel = o; rep_sel = r; word_sz = w; dir_flag = df;
    si_in = si; di_in = di; cx_in = cx; acc_in = acc;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < MSZ; i++) img[i] = 8'($urandom % 4);
    repeat (3) @(negedge clk);
    chk("R13 reset idle", {busy, done, mem_req}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    ds_seg = 16'h0010; es_seg = 16'h0040; ovr_seg = 16'h0080; zf_in = 1;

    // R10: repeat with zero count
    set_cmd(3'd0, 2'd1, 0, 0, 16'h0100, 16'h0200, 16'd0, 16'h1234);
    run_cmd(0);
    chk("R10 zero-count latency", last_cycles, 1);
    chk("R10 zero-count no access", acc_cnt, 0);
    // R10: unknown op
    set_cmd(3'd6, 2'd0, 1, 0, 16'h0100, 16'h0200, 16'd5, 16'h1234);
    run_cmd(0);
    chk("R10 unknown-op latency", last_cycles, 1);

    // R11: no repeat, word move, count unchanged
    set_cmd(3'd0, 2'd0, 1, 0, 16'h0101, 16'h0301, 16'd5, 16'h0);
    run_cmd(0);
    chk("R11 count held", cx_out, 16'd5);

    // R9: scan until match, pointer lands one past it
    for (int i = 0; i < 8; i++) img[loc(es_seg, 16'h0400 + 16'(i))] = 8'h10 + 8'(i);
    set_cmd(3'd2, 2'd2, 0, 0, 16'h0, 16'h0400, 16'd8, 16'hFF13);
    zf_in = 0;
    run_cmd(0);
    chk("R9 scan di past match", di_out, 16'h0404);
    chk("R9 scan count left", cx_out, 16'd4);
    chk("R6 scan zf on match", zf_out, 1'b1);

    // R8/R3: equal-repeat word compare downward with a mismatch
    for (int i = 0; i < 12; i++) begin
      img[loc(ds_seg, 16'h0500 - 16'(i))] = 8'h33;
      img[loc(es_seg, 16'h0600 - 16'(i))] = (i == 5) ? 8'h34 : 8'h33;
    end
    set_cmd(3'd1, 2'd1, 1, 1, 16'h04FF, 16'h05FF, 16'd6, 16'h0);
    zf_in = 1;
    run_cmd(0);
    chk("R8 compare stops at mismatch", zf_out, 1'b0);

    // R2: override set on a store must not move the destination
    ovr_en = 1;
    set_cmd(3'd4, 2'd1, 1, 0, 16'h0700, 16'h0700, 16'd3, 16'hBEEF);
    run_cmd(0);
    chk("R2 store at destination segment", img[loc(es_seg, 16'h0702)], 8'hEF);
    // R1/R5: byte load through override keeps high accumulator byte
    img[loc(ovr_seg, 16'h0020)] = 8'h5C;
    set_cmd(3'd3, 2'd0, 0, 0, 16'h0020, 16'h0000, 16'd1, 16'hAB00);
    run_cmd(0);
    chk("R1/R5 byte load via override", acc_out, 16'hAB5C);
    ovr_en = 0;

    // R13: start while busy is ignored
    set_cmd(3'd0, 2'd1, 0, 0, 16'h0800, 16'h0900, 16'd6, 16'h0);
    run_cmd(1);

    // random mix
    for (int n = 0; n < 80 && !aborted; n++) begin
      for (int i = 0; i < MSZ; i++) if ($urandom % 8 == 0) img[i] = 8'($urandom % 4);
      ds_seg = 16'($urandom); es_seg = 16'($urandom); ovr_seg = 16'($urandom);
      ovr_en = $urandom % 2; zf_in = $urandom % 2;
      set_cmd(3'($urandom % 6), 2'($urandom % 4), $urandom % 2, $urandom % 2,
              16'($urandom), 16'($urandom), 16'($urandom % 20), 16'($urandom % 4));
      run_cmd(0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule